// File: doc/BRIEF.md
# Two-Input Pair-Sequence Output Controller

This block is a synchronous Moore machine. On every rising clock edge it samples two input bits together as one pair. It drives a single output level. The level is not a detection pulse. It holds its value until a two-step sequence of pairs completes, and that sequence either clears it, sets it or flips it.

The machine stores two things: the class of the most recent sampled pair (01, 10 or anything else) and the present output level. The output comes straight from that stored level. A pair that completes a sequence is also remembered as the first step of the next sequence, so sequences may overlap.

Top module: `pair_seq_ctrl`

## Requirements
- R1: While `rst` is high on a rising edge, the next output is `level_out` = 0 and no pending first step is remembered. A pair sampled on the reset edge therefore cannot start a sequence.
- R2: A sample of pair (`in_a`,`in_b`) = (0,1) followed on the next edge by (1,1) makes `level_out` 0.
- R3: A sample of pair (1,0) followed on the next edge by (1,1) makes `level_out` 1.
- R4: A sample of pair (1,0) followed on the next edge by (0,1) inverts `level_out`.
- R5: On any edge that does not complete one of the sequences in R2 to R4, `level_out` keeps its previous value.
- R6: The second pair of a completed sequence also counts as the first pair of a following sequence. For example, the run 10, 01, 11 first inverts the level and then clears it.
- R7: A sampled pair (0,0) or (1,1) that completes no sequence discards any pending first step. For example, 10, 00, 11 and 10, 11, 11 each leave the level unchanged on their last edge.
- R8: `level_out` is registered. A new value becomes visible just after the edge that samples the second pair, and it does not change between edges when the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_a | input | 1 | First bit of the sampled pair |
| in_b | input | 1 | Second bit of the sampled pair |
| level_out | output | 1 | Held output level |

## Verification
The block has no parameters, so the bench builds the only configuration it has. That configuration is small enough to cover fully. From both starting levels, the bench applies every run of three pairs (64 runs per level) and checks each edge against an arithmetic model of the prefix and the level. This reaches every transition, every completion and every overlap. Directed runs then cover the overlap chain, prefix discard by 00 and 11, reset in the middle of a prefix, and inputs that change between edges.

// File: rtl/pair_seq_ctrl.sv
module pair_seq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic in_a,
  input  logic in_b,
  output logic level_out
);

  typedef enum logic [1:0] {PFX_NONE = 2'd0, PFX_LO_HI = 2'd1, PFX_HI_LO = 2'd2} pfx_t;

  pfx_t pfx_q, pfx_d;
  logic lvl_q, lvl_d;

  wire pair_01 = !in_a &&  in_b;
  wire pair_10 =  in_a && !in_b;
  wire pair_11 =  in_a &&  in_b;

  wire do_clr = (pfx_q == PFX_LO_HI) && pair_11;
  wire do_set = (pfx_q == PFX_HI_LO) && pair_11;
  wire do_tog = (pfx_q == PFX_HI_LO) && pair_01;

  always_comb begin
    if (pair_01)      pfx_d = PFX_LO_HI;
    else if (pair_10) pfx_d = PFX_HI_LO;
    else              pfx_d = PFX_NONE;
  end

  always_comb begin
    lvl_d = lvl_q;
    if (do_clr)      lvl_d = 1'b0;
    else if (do_set) lvl_d = 1'b1;
    else if (do_tog) lvl_d = !lvl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pfx_q <= PFX_NONE;
      lvl_q <= 1'b0;
    end else begin
      pfx_q <= pfx_d;
      lvl_q <= lvl_d;
    end
  end

  assign level_out = lvl_q;

endmodule

// File: rtl/pair_seq_ctrl_chk.sv
module pair_seq_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic in_a,
  input logic in_b,
  input logic level_out
);

  logic       prev_ok;
  logic [1:0] prev_pair;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ok   <= 1'b0;
      prev_pair <= 2'b00;
    end else begin
      prev_ok   <= 1'b1;
      prev_pair <= {in_a, in_b};
    end
  end

  wire seq_clr = prev_ok && prev_pair == 2'b01 && {in_a, in_b} == 2'b11;
  wire seq_set = prev_ok && prev_pair == 2'b10 && {in_a, in_b} == 2'b11;
  wire seq_tog = prev_ok && prev_pair == 2'b10 && {in_a, in_b} == 2'b01;

  assert_reset_low_R1: assert property (@(posedge clk) rst |=> !level_out);

  assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
    seq_clr |=> !level_out);

  assert_set_R3: assert property (@(posedge clk) disable iff (rst)
    seq_set |=> level_out);

  assert_toggle_R4: assert property (@(posedge clk) disable iff (rst)
    seq_tog |=> level_out != $past(level_out));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!seq_clr && !seq_set && !seq_tog) |=> $stable(level_out));

endmodule

bind pair_seq_ctrl pair_seq_ctrl_chk i_pair_seq_ctrl_chk (
  .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .level_out(level_out)
);

// File: tb/test_pair_seq_ctrl.sv
module test_pair_seq_ctrl;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_a = 1'b0;
  logic in_b = 1'b0;
  logic level_out;

  int checks = 0;
  int errors = 0;

  logic       ref_lvl = 1'b0;
  logic       ref_ok  = 1'b0;
  logic [1:0] ref_prev = 2'b00;

  always #(PERIOD/2) clk = !clk;

  pair_seq_ctrl i_pair_seq_ctrl (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .level_out(level_out)
  );

  task automatic check(input string tag, input logic exp);
    checks++;
    if (level_out !== exp) begin
      errors++;
      $display("FAIL %s: level_out=%b expected=%b at %0t", tag, level_out, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    ref_lvl = 1'b0; ref_ok = 1'b0; ref_prev = 2'b00;
    @(negedge clk);
    check("R1", 1'b0);
    rst = 1'b0;
  endtask

  task automatic step(input logic [1:0] p, input string force_tag);
    string tag;
    in_a = p[1]; in_b = p[0];
    @(posedge clk);
    tag = "R5";
    if (ref_ok && ref_prev == 2'b01 && p == 2'b11) begin ref_lvl = 1'b0; tag = "R2"; end
    else if (ref_ok && ref_prev == 2'b10 && p == 2'b11) begin ref_lvl = 1'b1; tag = "R3"; end
    else if (ref_ok && ref_prev == 2'b10 && p == 2'b01) begin ref_lvl = !ref_lvl; tag = "R4"; end
    ref_prev = p; ref_ok = 1'b1;
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    check(tag, ref_lvl);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    for (int start = 0; start < 2; start++) begin
      for (int s = 0; s < 64; s++) begin
        do_reset();
        if (start == 1) begin step(2'b10, ""); step(2'b11, "R3"); step(2'b00, "R7"); end
        step(s[5:4], "");
        step(s[3:2], "");
        step(s[1:0], "");
      end
    end

    do_reset();
    step(2'b10, ""); step(2'b01, "R6"); step(2'b11, "R6");
    step(2'b10, ""); step(2'b01, "R6"); step(2'b10, "R6"); step(2'b01, "R6");

    do_reset();
    step(2'b10, ""); step(2'b00, "R7"); step(2'b11, "R7");
    step(2'b10, ""); step(2'b11, "R3"); step(2'b11, "R7");
    step(2'b01, ""); step(2'b00, "R7"); step(2'b11, "R7");

    do_reset();
    step(2'b10, "");
    in_a = 1'b1; in_b = 1'b1; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1", 1'b0);
    rst = 1'b0;
    ref_lvl = 1'b0; ref_ok = 1'b0;
    step(2'b11, "R1");

    do_reset();
    step(2'b10, "");
    in_a = 1'b1; in_b = 1'b1;
    #(PERIOD/4);
    check("R8", 1'b0);
    @(posedge clk); #1;
    check("R8", 1'b1);
    in_a = 1'b0; in_b = 1'b0;
    #(PERIOD/4);
    check("R8", 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule